// File: doc/BRIEF.md
# Per-Subsystem Power Mode Controller

This controller governs the power mode of one processor subsystem. It holds the subsystem in one of three modes: running, a light sleep that only slows the processor clock, and a full sleep that cuts supply and clock to the processor and to every sub-domain beneath it. Software starts a transition by writing a two-bit mode field together with a start bit. From then on the controller drives the control codes for the clock multiplexer, the voltage converter setting, the converter enable, a set of sub-domain enables, a retention handshake and a reset request toward the subsystem. The converter, PLL and oscillator sit outside the block. One copy is built for each subsystem.

The two sleep depths end in different ways. An interrupt during light sleep puts back the previous clock selection, and the processor carries on where it stopped. Leaving full sleep, whether on an interrupt or on the hardware reset input, turns the supply back on and holds the subsystem reset for a fixed number of cycles, so the processor reboots at the medium setting. Before power is removed, the controller requests a retention save and waits for an acknowledge or a short timeout. A sticky wake-status mask records which sources caused each wake-up. This controller is not reset by the subsystem reset, so the mask survives a reboot until software clears it.

Top module: `psub_pwr_ctrl`

## Requirements
- R1: After reset the voltage setting is medium, so vsel and clk_sel are 01. conv_en, cpu_clk_en and every dom_en bit are 1, ret_req, sub_rst and start_o are 0, and wake_sts is 0.
- R2: In active mode, clk_sel and vsel both equal the stored voltage setting, coded 00 low, 01 medium and 10 high. A write whose setting field is 11 leaves the stored setting unchanged.
- R3: A write with mode 1 and start 1 in active mode enters light sleep on the following clock edge. clk_sel becomes 11, the oscillator bypass code, and conv_en, cpu_clk_en and all dom_en stay 1.
- R4: In light sleep, any interrupt line at 1 returns the block to active mode on the next edge. clk_sel goes back to the setting held before sleep, and sub_rst is not asserted.
- R5: A write with mode 2 and start 1 in active mode first raises ret_req for exactly one cycle. Power is removed on the edge after ret_done is seen high, or after 4 cycles in the retention phase if no acknowledge comes. So conv_en stays 1 for d+1 sampled cycles when ret_done arrives d cycles after ret_req (d below 4), and for 4 cycles when it never arrives.
- R6: In full sleep, conv_en, cpu_clk_en and every dom_en bit are 0.
- R7: In full sleep, any interrupt line or hw_rst_req wakes the subsystem. From the next edge, conv_en is 1, sub_rst is 1 for exactly 2 cycles, and vsel is 01. Afterwards the block is active with clk_sel 01.
- R8: At each wake-up, wake_sts bit i is set if irq[i] was 1 on the waking edge, and bit NUM_IRQ is set if the wake came from hw_rst_req. Bits stay set until sw_sts_clr. An interrupt while active does not change wake_sts.
- R9: start_o reads 1 for the single cycle after an accepted write with start 1 and then clears by itself. A start with mode 0 or mode 3 changes nothing. Writes made outside active mode are ignored, including their setting field.
- R10: A sleep request is ignored while wake_sts is non-zero.
- R11: hw_rst_req has no effect in active mode or in light sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Active-low reset of the controller itself |
| sw_wr | input | 1 | Software write strobe for mode, start and setting |
| sw_mode | input | 2 | Requested mode: 0 active, 1 light sleep, 2 full sleep |
| sw_start | input | 1 | Start bit carried by the write |
| sw_vset | input | 2 | Voltage/frequency setting carried by the write |
| sw_sts_clr | input | 1 | Clears the wake-status mask |
| irq | input | NUM_IRQ | Wake interrupt lines, level sensitive |
| hw_rst_req | input | 1 | Hardware reset request, wakes from full sleep |
| ret_done | input | 1 | Retention save acknowledge |
| start_o | output | 1 | Read-back of the self-clearing start bit |
| clk_sel | output | 2 | Processor clock multiplexer code |
| vsel | output | 2 | Converter voltage setting code |
| conv_en | output | 1 | Converter output enable |
| cpu_clk_en | output | 1 | Processor clock enable |
| dom_en | output | NUM_DOM | Sub-domain power enables |
| ret_req | output | 1 | Retention save request pulse |
| sub_rst | output | 1 | Subsystem wake-up reset request |
| wake_sts | output | NUM_IRQ+1 | Sticky wake-source mask |

## Verification
The retention phase is the hardest part to reach, because the block leaves it for one of two reasons. The bench sweeps the acknowledge delay across every cycle of the timeout window and also runs once with no acknowledge, then counts how many cycles the converter stays enabled. To exercise the status and ignored-request rules, the bench first leaves the wake mask uncleared and then issues a sleep request. It also writes new settings during light sleep and checks afterwards that the old clock selection comes back.

// File: rtl/psub_pwr_pkg.sv
package psub_pwr_pkg;
   typedef enum logic [2:0] {
      ST_ACTIVE  = 3'd0,
      ST_SHALLOW = 3'd1,
      ST_RETAIN  = 3'd2,
      ST_DEEP    = 3'd3,
      ST_REBOOT  = 3'd4
   } pwr_state_t;

   localparam logic [1:0] VS_LOW    = 2'b00;
   localparam logic [1:0] VS_MED    = 2'b01;
   localparam logic [1:0] VS_HIGH   = 2'b10;
   localparam logic [1:0] CS_OSC    = 2'b11;

   localparam logic [1:0] MODE_RUN  = 2'd0;
   localparam logic [1:0] MODE_LITE = 2'd1;
   localparam logic [1:0] MODE_FULL = 2'd2;
endpackage

// File: rtl/psub_pwr_req_regs.sv
module psub_pwr_req_regs
   import psub_pwr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sw_wr,
   input  logic [1:0] sw_mode,
   input  logic       sw_start,
   input  logic [1:0] sw_vset,
   input  logic       in_active,
   input  logic       reboot_load,
   output logic [1:0] mode_q,
   output logic       start_q,
   output logic [1:0] vset_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MODE_RUN;
         start_q <= 1'b0;
         vset_q  <= VS_MED;
      end else begin
         start_q <= 1'b0;
         if (reboot_load) begin
            vset_q <= VS_MED;
         end else if (sw_wr && in_active) begin
            mode_q  <= sw_mode;
            start_q <= sw_start;
            if (sw_vset != CS_OSC) vset_q <= sw_vset;
         end
      end
   end
endmodule

// File: rtl/psub_pwr_fsm.sv
module psub_pwr_fsm
   import psub_pwr_pkg::*;
#(
   parameter int RET_TIMEOUT = 4,
   parameter int RST_CYCLES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_q,
   input  logic [1:0] mode_q,
   input  logic       sts_busy,
   input  logic       irq_any,
   input  logic       hw_rst_req,
   input  logic       ret_done,
   output pwr_state_t state,
   output logic       ret_first,
   output logic       wake_evt,
   output logic       wake_hw,
   output logic       reboot_load
);
   localparam int CNT_MAX = (RET_TIMEOUT > RST_CYCLES) ? RET_TIMEOUT : RST_CYCLES;
   localparam int CW      = $clog2(CNT_MAX + 1);
   localparam logic [CW-1:0] RET_LAST = CW'(RET_TIMEOUT - 1);
   localparam logic [CW-1:0] RST_LAST = CW'(RST_CYCLES - 1);

   pwr_state_t    nxt;
   logic [CW-1:0] cnt, cnt_nxt;
   logic          deep_wake;

   assign deep_wake   = (state == ST_DEEP) && (irq_any || hw_rst_req);
   assign reboot_load = deep_wake;
   assign wake_hw     = deep_wake && hw_rst_req;
   assign wake_evt    = deep_wake || ((state == ST_SHALLOW) && irq_any);
   assign ret_first   = (state == ST_RETAIN) && (cnt == '0);

   always_comb begin
      nxt     = state;
      cnt_nxt = cnt;
      unique case (state)
         ST_ACTIVE: begin
            if (start_q && !sts_busy) begin
               if (mode_q == MODE_LITE) nxt = ST_SHALLOW;
               else if (mode_q == MODE_FULL) begin
                  nxt     = ST_RETAIN;
                  cnt_nxt = '0;
               end
            end
         end
         ST_SHALLOW: if (irq_any) nxt = ST_ACTIVE;
         ST_RETAIN: begin
            if (ret_done || cnt == RET_LAST) nxt = ST_DEEP;
            else cnt_nxt = cnt + 1'b1;
         end
         ST_DEEP: begin
            if (deep_wake) begin
               nxt     = ST_REBOOT;
               cnt_nxt = '0;
            end
         end
         ST_REBOOT: begin
            if (cnt == RST_LAST) nxt = ST_ACTIVE;
            else cnt_nxt = cnt + 1'b1;
         end
         default: nxt = ST_ACTIVE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_ACTIVE;
         cnt   <= '0;
      end else begin
         state <= nxt;
         cnt   <= cnt_nxt;
      end
   end
endmodule

// File: rtl/psub_pwr_wake_log.sv
module psub_pwr_wake_log #(
   parameter int NUM_IRQ = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wake_evt,
   input  logic               wake_hw,
   input  logic [NUM_IRQ-1:0] irq,
   input  logic               clr,
   output logic [NUM_IRQ:0]   sts,
   output logic               busy
);
   assign busy = |sts;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts <= '0;
      else if (wake_evt) sts <= sts | {wake_hw, irq};
      else if (clr) sts <= '0;
   end
endmodule

// File: rtl/psub_pwr_outdec.sv
module psub_pwr_outdec
   import psub_pwr_pkg::*;
#(
   parameter int NUM_DOM = 3
) (
   input  pwr_state_t         state,
   input  logic [1:0]         vset_q,
   input  logic               ret_first,
   output logic [1:0]         clk_sel,
   output logic [1:0]         vsel,
   output logic               conv_en,
   output logic               cpu_clk_en,
   output logic [NUM_DOM-1:0] dom_en,
   output logic               ret_req,
   output logic               sub_rst
);
   logic powered;

   assign powered    = (state != ST_DEEP);
   assign conv_en    = powered;
   assign cpu_clk_en = powered;
   assign vsel       = vset_q;
   assign clk_sel    = (state == ST_SHALLOW || state == ST_DEEP) ? CS_OSC : vset_q;
   assign ret_req    = ret_first;
   assign sub_rst    = (state == ST_REBOOT);

   for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
      assign dom_en[g] = powered;
   end
endmodule

// File: rtl/psub_pwr_ctrl.sv
module psub_pwr_ctrl
   import psub_pwr_pkg::*;
#(
   parameter int NUM_IRQ     = 4,
   parameter int NUM_DOM     = 3,
   parameter int RET_TIMEOUT = 4,
   parameter int RST_CYCLES  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sw_wr,
   input  logic [1:0]         sw_mode,
   input  logic               sw_start,
   input  logic [1:0]         sw_vset,
   input  logic               sw_sts_clr,
   input  logic [NUM_IRQ-1:0] irq,
   input  logic               hw_rst_req,
   input  logic               ret_done,
   output logic               start_o,
   output logic [1:0]         clk_sel,
   output logic [1:0]         vsel,
   output logic               conv_en,
   output logic               cpu_clk_en,
   output logic [NUM_DOM-1:0] dom_en,
   output logic               ret_req,
   output logic               sub_rst,
   output logic [NUM_IRQ:0]   wake_sts
);
   if (NUM_IRQ < 1 || NUM_IRQ > 8) begin : g_bad_irq
      $error("NUM_IRQ must lie in 1..8");
   end
   if (NUM_DOM < 1) begin : g_bad_dom
      $error("NUM_DOM must be at least 1");
   end
   if (RET_TIMEOUT < 1 || RST_CYCLES < 1) begin : g_bad_cnt
      $error("RET_TIMEOUT and RST_CYCLES must be at least 1");
   end

   pwr_state_t state;
   logic [1:0] mode_q, vset_q;
   logic       start_q, ret_first, wake_evt, wake_hw, reboot_load, sts_busy;

   assign start_o = start_q;

   psub_pwr_req_regs u_regs (
      .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_mode(sw_mode),
      .sw_start(sw_start), .sw_vset(sw_vset),
      .in_active(state == ST_ACTIVE), .reboot_load(reboot_load),
      .mode_q(mode_q), .start_q(start_q), .vset_q(vset_q)
   );

   psub_pwr_fsm #(.RET_TIMEOUT(RET_TIMEOUT), .RST_CYCLES(RST_CYCLES)) u_fsm (
      .clk(clk), .rst_n(rst_n), .start_q(start_q), .mode_q(mode_q),
      .sts_busy(sts_busy), .irq_any(|irq), .hw_rst_req(hw_rst_req),
      .ret_done(ret_done), .state(state), .ret_first(ret_first),
      .wake_evt(wake_evt), .wake_hw(wake_hw), .reboot_load(reboot_load)
   );

   psub_pwr_wake_log #(.NUM_IRQ(NUM_IRQ)) u_log (
      .clk(clk), .rst_n(rst_n), .wake_evt(wake_evt), .wake_hw(wake_hw),
      .irq(irq), .clr(sw_sts_clr), .sts(wake_sts), .busy(sts_busy)
   );

   psub_pwr_outdec #(.NUM_DOM(NUM_DOM)) u_out (
      .state(state), .vset_q(vset_q), .ret_first(ret_first),
      .clk_sel(clk_sel), .vsel(vsel), .conv_en(conv_en),
      .cpu_clk_en(cpu_clk_en), .dom_en(dom_en), .ret_req(ret_req),
      .sub_rst(sub_rst)
   );
endmodule

// File: rtl/psub_pwr_ctrl_chk.sv
module psub_pwr_ctrl_chk #(
   parameter int NUM_IRQ = 4,
   parameter int NUM_DOM = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               sw_wr,
   input logic               sw_sts_clr,
   input logic               ret_done,
   input logic               start_o,
   input logic [1:0]         clk_sel,
   input logic [1:0]         vsel,
   input logic               conv_en,
   input logic               cpu_clk_en,
   input logic [NUM_DOM-1:0] dom_en,
   input logic               ret_req,
   input logic               sub_rst,
   input logic [NUM_IRQ:0]   wake_sts
);
   a_r6_deep_all_off: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_en |-> (dom_en == '0 && !cpu_clk_en));

   a_r3_shallow_supply: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_sel == 2'b11 && cpu_clk_en) |-> (conv_en && dom_en == '1));

   a_r5_ret_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ret_req |=> !ret_req);

   a_r5_no_early_off: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_req && !ret_done) |=> conv_en);

   a_r7_reset_after_deep: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sub_rst) |-> $past(!conv_en));

   a_r7_reboot_medium: assert property (@(posedge clk) disable iff (!rst_n)
      sub_rst |-> (vsel == 2'b01 && conv_en));

   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sw_sts_clr) |-> ((wake_sts & $past(wake_sts)) == $past(wake_sts)));

   a_r9_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (start_o && !sw_wr) |=> !start_o);
endmodule

bind psub_pwr_ctrl psub_pwr_ctrl_chk #(.NUM_IRQ(NUM_IRQ), .NUM_DOM(NUM_DOM)) u_chk (
   .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_sts_clr(sw_sts_clr),
   .ret_done(ret_done), .start_o(start_o), .clk_sel(clk_sel), .vsel(vsel),
   .conv_en(conv_en), .cpu_clk_en(cpu_clk_en), .dom_en(dom_en),
   .ret_req(ret_req), .sub_rst(sub_rst), .wake_sts(wake_sts)
);

// File: tb/psub_pwr_ctrl_tb.sv
`timescale 1ns/1ps
module psub_pwr_ctrl_tb;
   localparam int NI = 4;
   localparam int ND = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sw_wr = 1'b0, sw_start = 1'b0, sw_sts_clr = 1'b0;
   logic [1:0] sw_mode = 2'd0, sw_vset = 2'd1;
   logic [NI-1:0] irq = '0;
   logic hw_rst_req = 1'b0, ret_done = 1'b0;
   logic start_o, conv_en, cpu_clk_en, ret_req, sub_rst;
   logic [1:0] clk_sel, vsel;
   logic [ND-1:0] dom_en;
   logic [NI:0] wake_sts;

   int tests = 0, fails = 0;
   bit done = 0;

   always #2 clk = ~clk;

   psub_pwr_ctrl #(.NUM_IRQ(NI), .NUM_DOM(ND)) u_dut (
      .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_mode(sw_mode),
      .sw_start(sw_start), .sw_vset(sw_vset), .sw_sts_clr(sw_sts_clr),
      .irq(irq), .hw_rst_req(hw_rst_req), .ret_done(ret_done),
      .start_o(start_o), .clk_sel(clk_sel), .vsel(vsel), .conv_en(conv_en),
      .cpu_clk_en(cpu_clk_en), .dom_en(dom_en), .ret_req(ret_req),
      .sub_rst(sub_rst), .wake_sts(wake_sts)
   );

   task automatic chk(input int act, input int exp, input string tag);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] m, input logic s, input logic [1:0] v);
      sw_wr = 1'b1; sw_mode = m; sw_start = s; sw_vset = v;
      tick();
      sw_wr = 1'b0; sw_start = 1'b0;
   endtask

   task automatic clr_sts();
      sw_sts_clr = 1'b1; tick(); sw_sts_clr = 1'b0;
   endtask

   task automatic pulse_irq(input logic [NI-1:0] p);
      irq = p; tick(); irq = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int cur;
      tick(); tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk(clk_sel, 1, "R1 clk_sel");
      chk(vsel, 1, "R1 vsel");
      chk({conv_en, cpu_clk_en, dom_en}, 5'b11111, "R1 power on");
      chk({ret_req, sub_rst, start_o}, 0, "R1 pulses low");
      chk(wake_sts, 0, "R1 wake_sts");

      // R2 setting sweep, including the invalid code 11
      for (int v = 0; v < 3; v++) begin
         wr(2'd0, 1'b0, 2'(v));
         chk(clk_sel, v, "R2 clk_sel follows setting");
         chk(vsel, v, "R2 vsel follows setting");
      end
      wr(2'd0, 1'b0, 2'd3);
      chk(clk_sel, 2, "R2 code 11 ignored");

      // R9 start with mode 0 and mode 3 ignored, start self-clears
      wr(2'd0, 1'b1, 2'd2);
      chk(start_o, 1, "R9 start reads 1");
      tick();
      chk(start_o, 0, "R9 start cleared");
      chk(clk_sel, 2, "R9 mode 0 no change");
      wr(2'd3, 1'b1, 2'd2);
      tick(); tick();
      chk({clk_sel, conv_en}, {2'd2, 1'b1}, "R9 mode 3 no change");

      // R8 irq in active does not set status
      pulse_irq('1);
      tick();
      chk(wake_sts, 0, "R8 irq in active ignored");

      // R3/R4/R8 light sleep sweep over settings and lines
      for (int v = 0; v < 3; v++) begin
         for (int i = 0; i < NI; i++) begin
            wr(2'd0, 1'b0, 2'(v));
            wr(2'd1, 1'b1, 2'(v));
            tick();
            chk(clk_sel, 3, "R3 bypass code");
            chk({conv_en, cpu_clk_en, dom_en}, 5'b11111, "R3 supply kept");
            wr(2'd0, 1'b0, 2'((v + 1) % 3));
            chk(clk_sel, 3, "R9 write in sleep ignored");
            if (i == 0) begin
               hw_rst_req = 1'b1; tick(); hw_rst_req = 1'b0;
               chk(clk_sel, 3, "R11 hw reset in light sleep");
               chk(wake_sts, 0, "R11 no status");
            end
            pulse_irq(NI'(1) << i);
            chk(clk_sel, v, "R4 previous setting restored");
            chk(sub_rst, 0, "R4 no reset");
            chk(wake_sts, 1 << i, "R8 line recorded");
            clr_sts();
            chk(wake_sts, 0, "R8 cleared");
         end
      end

      // R10 sleep request ignored while status non-zero
      wr(2'd1, 1'b1, 2'd2);
      tick();
      pulse_irq(4'b0010);
      wr(2'd1, 1'b1, 2'd2);
      tick(); tick();
      chk(clk_sel, 2, "R10 request ignored");
      chk(wake_sts, 2, "R10 status kept");
      clr_sts();

      // R11 hw reset in active ignored
      hw_rst_req = 1'b1; tick(); hw_rst_req = 1'b0;
      chk({clk_sel, sub_rst, conv_en}, {2'd2, 1'b0, 1'b1}, "R11 hw reset in active");

      // R5/R6/R7/R8 full sleep, ack delay sweep, d = 4 means no ack
      for (int d = 0; d <= 4; d++) begin
         wr(2'd2, 1'b1, 2'd2);
         tick();
         chk(ret_req, 1, "R5 ret_req raised");
         cur = 0;
         for (int k = 0; k < 12; k++) begin
            ret_done = (k == d);
            if (k == 1 && conv_en) chk(ret_req, 0, "R5 ret_req one cycle");
            if (!conv_en) break;
            cur++;
            tick();
         end
         ret_done = 1'b0;
         chk(cur, (d < 4) ? d + 1 : 4, "R5 power-off timing");
         chk({conv_en, cpu_clk_en, dom_en}, 0, "R6 all off");
         if (d == 4) begin
            hw_rst_req = 1'b1; tick(); hw_rst_req = 1'b0;
         end else begin
            pulse_irq(NI'(d + 5));
         end
         chk({conv_en, vsel}, {1'b1, 2'd1}, "R7 supply on at medium");
         cur = 0;
         for (int k = 0; k < 8; k++) begin
            if (!sub_rst) break;
            cur++;
            tick();
         end
         chk(cur, 2, "R7 reset length");
         chk(clk_sel, 1, "R7 reboot medium");
         chk(wake_sts, (d == 4) ? (1 << NI) : ((d + 5) & ((1 << NI) - 1)), "R8 wake sources");
         clr_sts();
         wr(2'd0, 1'b0, 2'd2);
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule